// File: doc/BRIEF.md
# Jump-History Prefetch Address Generator

This block produces the stream of instruction prefetch addresses for a fetch unit. It normally steps forward one instruction word at a time. It also keeps a small table of branches that were seen taken, each line recording the address the branch left from and the address it went to. Every address offered to the fetch port is compared with all recorded from-addresses in the same cycle. When one matches, the address that follows it in the stream is the recorded target rather than the next word. The offered address carries a tag bit that marks this case, and the bit travels with the fetched instruction to the branch logic downstream.

When the branch logic resolves a real branch, it reports the branch address, the outcome, the target and the tag bit that came with that instruction. A taken branch that is not in the table is recorded. The line to overwrite is chosen in strict arrival order. A predicted branch that turns out not taken has its line removed. When the outcome disagrees with the tag, the prefetch stream is flushed and restarts one cycle later at the correct address: the target if the branch was taken, the word after the branch if it was not.

The fetch port follows valid/ready rules. An address is consumed only in a cycle where valid and ready are both high. While ready is low, the offered address and tag stay unchanged, except in the cycle after a branch report: such a report may redirect the stream or change the table. Branch reports are plain control inputs with no handshake.

Top module: `jtrace_prefetch`

## Requirements
- R1: While reset is asserted, fetch_valid is low. From the first clock edge after reset is released, fetch_valid is high, fetch_addr equals RESET_ADDR, fetch_pred is 0 and the table holds no valid line.
- R2: When an address is consumed, no redirect is requested and fetch_pred is 0, the next offered address is the consumed address plus one.
- R3: While fetch_ready is low and br_valid was low in the previous cycle, fetch_addr and fetch_pred keep their values.
- R4: fetch_pred is 1 exactly when fetch_addr equals the from-address of a valid table line. When such an address is consumed without a redirect, the next offered address is that line's recorded target.
- R5: A report with br_valid=1 and br_taken=1 whose br_pc is not in the table records a line with from-address br_pc and target br_target.
- R6: A taken report whose br_pc is already in the table writes no further line, so a single later drop removes the branch completely.
- R7: Lines are replaced in strict arrival order of recordings. Lines emptied by a drop are not reused early. After LINES+1 recordings the first recorded branch is gone and the second remains.
- R8: A report where br_taken differs from br_pred redirects the stream. In the next cycle fetch_addr is br_target if br_taken=1, or br_pc+1 if br_taken=0. The redirect takes priority over a handshake or a table hit in the same cycle.
- R9: A report with br_taken=0 and br_pred=1 whose br_pc is in the table invalidates that line only. Other lines are untouched.
- R10: A report where br_taken equals br_pred causes no redirect. A not-taken, unpredicted report also leaves the table unchanged.
- R11: Sequential addresses wrap modulo 2^AW, so the address after the all-ones address is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | output | 1 | Prefetch address offered |
| fetch_ready | input | 1 | Fetch port accepts the offered address |
| fetch_addr | output | AW | Offered prefetch word address |
| fetch_pred | output | 1 | Successor of this address is a table-predicted target |
| br_valid | input | 1 | A branch resolution is reported this cycle |
| br_pc | input | AW | Address of the resolved branch |
| br_target | input | AW | Target of the resolved branch |
| br_taken | input | 1 | Branch was actually taken |
| br_pred | input | 1 | Tag bit that accompanied the branch when it was fetched |

## Verification
The bench builds the block with AW=16, LINES=8 and RESET_ADDR=0. The 16-bit width puts the wrap from 16'hFFFF to zero one redirect away. Eight lines let nine recordings expose the exact eviction point of the arrival-order replacement. The bench steers the stream to any address with a not-taken, predicted report on the preceding word. This makes table contents visible at the ports as the tag and the next address, without reading internal state.

// File: rtl/jt_pkg.sv
package jt_pkg;
  // action applied to the history table by a branch resolution
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_RECORD = 2'd1,
    ACT_DROP   = 2'd2
  } jt_act_e;
endpackage

// File: rtl/jt_table.sv
module jt_table
  import jt_pkg::*;
#(
  parameter int AW    = 16,
  parameter int LINES = 8,
  localparam int IW   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] look_addr,
  output logic          look_hit,
  output logic [AW-1:0] look_to,
  input  logic [AW-1:0] br_addr,
  output logic          br_hit,
  input  jt_act_e       act,
  input  logic [AW-1:0] wr_to
);
  logic [LINES-1:0] vld_q;
  logic [AW-1:0]    from_q [LINES];
  logic [AW-1:0]    to_q   [LINES];
  logic [IW-1:0]    ptr_q;
  logic [LINES-1:0] look_m;
  logic [LINES-1:0] br_m;
  logic [IW-1:0]    br_idx;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign look_m[i] = vld_q[i] && (from_q[i] == look_addr);
    assign br_m[i]   = vld_q[i] && (from_q[i] == br_addr);
  end

  assign look_hit = |look_m;
  assign br_hit   = |br_m;

  always_comb begin
    look_to = '0;
    br_idx  = '0;
    for (int i = 0; i < LINES; i++) begin
      look_to = look_to | ({AW{look_m[i]}} & to_q[i]);
      if (br_m[i]) br_idx = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (act == ACT_RECORD) begin
      vld_q[ptr_q] <= 1'b1;
      ptr_q <= (ptr_q == IW'(LINES - 1)) ? '0 : ptr_q + IW'(1);
    end else if (act == ACT_DROP) begin
      vld_q[br_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (act == ACT_RECORD) begin
      from_q[ptr_q] <= br_addr;
      to_q[ptr_q]   <= wr_to;
    end
  end

  // a from-address is never held by two lines
  p_unique_look_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_m));
  p_unique_br_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(br_m));
  p_record_new_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_RECORD) |-> !br_hit);
  p_drop_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_DROP) |-> br_hit);
  p_record_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_RECORD) |=> br_hit || ($past(br_addr) != br_addr));
endmodule

// File: rtl/jt_resolve.sv
module jt_resolve
  import jt_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          br_valid,
  input  logic [AW-1:0] br_pc,
  input  logic [AW-1:0] br_target,
  input  logic          br_taken,
  input  logic          br_pred,
  input  logic          br_hit,
  output jt_act_e       act,
  output logic          redirect,
  output logic [AW-1:0] restart_addr
);
  always_comb begin
    act = ACT_NONE;
    if (br_valid) begin
      if (br_taken && !br_hit)                 act = ACT_RECORD;
      else if (!br_taken && br_pred && br_hit) act = ACT_DROP;
    end
  end

  assign redirect     = br_valid && (br_taken != br_pred);
  assign restart_addr = br_taken ? br_target : br_pc + AW'(1);

  p_no_dup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_taken && br_hit) |-> (act == ACT_NONE));
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !br_taken && !br_pred) |-> (act == ACT_NONE) && !redirect);
  p_drop_only_missed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_DROP) |-> redirect && !br_taken);
endmodule

// File: rtl/jt_fetch.sv
module jt_fetch #(
  parameter int            AW         = 16,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_ready,
  input  logic          look_hit,
  input  logic [AW-1:0] look_to,
  input  logic          redirect,
  input  logic [AW-1:0] restart_addr,
  output logic          fetch_valid,
  output logic [AW-1:0] fetch_addr
);
  logic          vld_q;
  logic [AW-1:0] pc_q;
  logic          take;

  assign take        = vld_q && fetch_ready;
  assign fetch_valid = vld_q;
  assign fetch_addr  = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pc_q  <= RESET_ADDR;
    end else begin
      vld_q <= 1'b1;
      if (redirect)  pc_q <= restart_addr;
      else if (take) pc_q <= look_hit ? look_to : pc_q + AW'(1);
    end
  end

  p_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !redirect && !look_hit) |=> (fetch_addr == $past(fetch_addr) + AW'(1)));
  p_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !redirect && look_hit) |=> (fetch_addr == $past(look_to)));
  p_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (fetch_addr == $past(restart_addr)));
  p_hold_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready && !redirect) |=> $stable(fetch_addr));
  p_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> fetch_valid);
endmodule

// File: rtl/jtrace_prefetch.sv
module jtrace_prefetch
  import jt_pkg::*;
#(
  parameter int            AW         = 16,
  parameter int            LINES      = 8,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          fetch_valid,
  input  logic          fetch_ready,
  output logic [AW-1:0] fetch_addr,
  output logic          fetch_pred,
  input  logic          br_valid,
  input  logic [AW-1:0] br_pc,
  input  logic [AW-1:0] br_target,
  input  logic          br_taken,
  input  logic          br_pred
);
  logic          look_hit;
  logic [AW-1:0] look_to;
  logic          br_hit;
  jt_act_e       act;
  logic          redirect;
  logic [AW-1:0] restart_addr;

  jt_table #(.AW(AW), .LINES(LINES)) u_table (
    .clk(clk), .rst_n(rst_n),
    .look_addr(fetch_addr), .look_hit(look_hit), .look_to(look_to),
    .br_addr(br_pc), .br_hit(br_hit), .act(act), .wr_to(br_target)
  );

  jt_resolve #(.AW(AW)) u_resolve (
    .clk(clk), .rst_n(rst_n),
    .br_valid(br_valid), .br_pc(br_pc), .br_target(br_target),
    .br_taken(br_taken), .br_pred(br_pred), .br_hit(br_hit),
    .act(act), .redirect(redirect), .restart_addr(restart_addr)
  );

  jt_fetch #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_fetch (
    .clk(clk), .rst_n(rst_n), .fetch_ready(fetch_ready),
    .look_hit(look_hit), .look_to(look_to),
    .redirect(redirect), .restart_addr(restart_addr),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr)
  );

  assign fetch_pred = fetch_valid && look_hit;

  p_hold_offer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready && !br_valid) |=> $stable(fetch_addr) && $stable(fetch_pred));
  p_quiet_report_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && (br_taken == br_pred) && !fetch_ready) |=> $stable(fetch_addr));
endmodule

// File: tb/tb_jtrace_prefetch.sv
module tb_jtrace_prefetch;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_valid;
  logic          fetch_ready = 1'b0;
  logic [AW-1:0] fetch_addr;
  logic          fetch_pred;
  logic          br_valid = 1'b0;
  logic [AW-1:0] br_pc = '0;
  logic [AW-1:0] br_target = '0;
  logic          br_taken = 1'b0;
  logic          br_pred = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  jtrace_prefetch #(.AW(AW), .LINES(8), .RESET_ADDR(16'h0000)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_addr(fetch_addr), .fetch_pred(fetch_pred), .br_valid(br_valid),
    .br_pc(br_pc), .br_target(br_target), .br_taken(br_taken), .br_pred(br_pred)
  );

  // from-address, target pairs recorded then probed
  localparam logic [31:0] VEC [4] = '{
    {16'h0100, 16'h0040},
    {16'h0200, 16'h0300},
    {16'h0305, 16'h0010},
    {16'hFFFF, 16'h1234}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic report(input logic [AW-1:0] pc, input logic [AW-1:0] tgt,
                        input logic tk, input logic pr);
    br_valid = 1'b1; br_pc = pc; br_target = tgt; br_taken = tk; br_pred = pr;
    step();
    br_valid = 1'b0;
  endtask

  // steer the stream: predicted-but-not-taken report on the word before a
  task automatic jump_to(input logic [AW-1:0] a);
    report(a - 16'd1, 16'h0000, 1'b0, 1'b1);
    chk("R8 steer", 32'(fetch_addr), 32'(a));
  endtask

  task automatic record(input logic [AW-1:0] f, input logic [AW-1:0] t);
    report(f, t, 1'b1, 1'b0);
    chk("R8 taken redirect", 32'(fetch_addr), 32'(t));
  endtask

  task automatic handshake();
    fetch_ready = 1'b1;
    step();
    fetch_ready = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    fetch_ready = 1'b0;
    br_valid = 1'b0;
    repeat (3) step();
    chk("R1 valid low in reset", 32'(fetch_valid), 32'd0);
    rst_n = 1'b1;
    step();
    chk("R1 valid", 32'(fetch_valid), 32'd1);
    chk("R1 addr", 32'(fetch_addr), 32'h0000);
    chk("R1 pred", 32'(fetch_pred), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step();
    do_reset();

    // R2 sequential stepping
    jump_to(16'h0500);
    for (int k = 1; k <= 3; k++) begin
      handshake();
      chk("R2 next addr", 32'(fetch_addr), 32'(16'h0500 + k));
      chk("R2 pred low", 32'(fetch_pred), 32'd0);
    end

    // R3 hold under back-pressure
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R3 held addr", 32'(fetch_addr), 32'h0503);
    end

    // R11 wrap
    jump_to(16'hFFFF);
    handshake();
    chk("R11 wrap", 32'(fetch_addr), 32'h0000);

    // R5 / R4 table walk
    for (int v = 0; v < 4; v++) record(VEC[v][31:16], VEC[v][15:0]);
    for (int v = 0; v < 4; v++) begin
      jump_to(VEC[v][31:16]);
      chk("R4 tag on hit", 32'(fetch_pred), 32'd1);
      handshake();
      chk("R5 recorded target", 32'(fetch_addr), 32'(VEC[v][15:0]));
      chk("R4 tag on landing", 32'(fetch_pred), 32'd0);
    end

    // R10 agreeing reports
    jump_to(16'h0600);
    report(16'h0100, 16'h0040, 1'b1, 1'b1);
    chk("R10 taken as predicted", 32'(fetch_addr), 32'h0600);
    report(16'h0650, 16'h0000, 1'b0, 1'b0);
    chk("R10 not taken unpredicted", 32'(fetch_addr), 32'h0600);
    jump_to(16'h0650);
    chk("R10 nothing recorded", 32'(fetch_pred), 32'd0);

    // R6 no duplicate: one drop removes 0x0100 completely
    report(16'h0100, 16'h0000, 1'b0, 1'b1);
    chk("R8 not-taken restart", 32'(fetch_addr), 32'h0101);
    jump_to(16'h0100);
    chk("R6 single line dropped", 32'(fetch_pred), 32'd0);

    // R9 drop one line, others stay
    report(16'h0200, 16'h0000, 1'b0, 1'b1);
    chk("R9 restart", 32'(fetch_addr), 32'h0201);
    jump_to(16'h0200);
    chk("R9 line dropped", 32'(fetch_pred), 32'd0);
    jump_to(16'h0305);
    chk("R9 other kept", 32'(fetch_pred), 32'd1);

    // R8 redirect beats hit plus handshake
    fetch_ready = 1'b1;
    report(16'h0700, 16'h0000, 1'b0, 1'b1);
    fetch_ready = 1'b0;
    chk("R8 redirect priority", 32'(fetch_addr), 32'h0701);

    // R7 arrival-order replacement
    do_reset();
    for (int k = 0; k < 9; k++) begin
      record(16'(16'h0800 + 16 * k), 16'(16'h0900 + k));
      if (k == 7) begin
        jump_to(16'h0800);
        chk("R7 first kept at full", 32'(fetch_pred), 32'd1);
      end
    end
    jump_to(16'h0800);
    chk("R7 oldest evicted", 32'(fetch_pred), 32'd0);
    jump_to(16'h0810);
    chk("R7 second kept", 32'(fetch_pred), 32'd1);
    handshake();
    chk("R7 second target", 32'(fetch_addr), 32'h0901);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule